// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block holds the exception side of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each stage reports its own fault flag for the instruction it holds. The block records that fault in a small tag that moves down the pipeline beside the instruction's valid bit and PC. Nothing is acted on where it is detected. The decision is made only when the instruction reaches the memory stage, which is the single commit point.

At the commit point the block either commits the instruction, takes a trap, or retires a return-from-exception. A trap stores a cause code and the faulting PC, enters kernel mode with interrupts masked, squashes the fetch, decode and execute stages, suppresses the faulting instruction's writeback and steers fetch to a fixed handler address. A return-from-exception that commits restores user mode, unmasks interrupts and steers fetch back to the saved PC. The datapath uses `redirect_valid`/`redirect_pc` as the top priority of its next-PC mux and uses the kill outputs to invalidate its own stage registers.

Top module: `exc_commit_ctrl`

## Requirements
- R1: A fault flag never redirects fetch in the cycle it is raised. It is acted on only in the cycle its instruction occupies the memory stage, which is three cycles after fetch for a fetch fault.
- R2: Cause codes are 1 = bad fetch address, 2 = illegal opcode (decode), 3 = overflow (execute) and 4 = data address fault (memory). When one instruction carries several faults, the code of the earliest stage is recorded.
- R3: An interrupt request (cause code 8) wins over any synchronous fault of the instruction in the memory stage.
- R4: In the cycle a trap is taken, `redirect_valid` is high with `redirect_pc` equal to the handler address, and all of `kill_fetch`, `kill_decode`, `kill_execute` and `wb_kill` are high. From the next cycle, `cause` holds the trap's code and `epc` holds the PC of the memory-stage instruction.
- R5: After a trap is taken, `kernel_mode` is 1 and `irq_enable` is 0.
- R6: A return-from-exception that reaches the memory stage with no fault and no winning interrupt commits. It raises `redirect_valid` with `redirect_pc` equal to the current `epc` and kills fetch, decode and execute, but not writeback. From the next cycle, `kernel_mode` is 0 and `irq_enable` is 1.
- R7: Instructions in fetch, decode or execute when a trap or return is taken never commit and never raise a trap.
- R8: During reset, `kernel_mode` is 1, `irq_enable` is 0, `cause` and `epc` are 0, and no redirect or commit is signalled.
- R9: `commit_valid` is high exactly when a valid instruction occupies the memory stage and no trap is taken there. Bubbles never commit.
- R10: An interrupt request is ignored while `irq_enable` is 0 or while the memory stage holds a bubble. Fault flags raised against bubbles are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| f_valid | input | 1 | Fetch stage holds an instruction |
| f_pc | input | PC_W | PC of the fetched instruction |
| f_exc | input | 1 | Bad fetch address for the fetched instruction |
| d_illegal | input | 1 | Illegal opcode for the decode-stage instruction |
| d_rfe | input | 1 | Decode-stage instruction is a return-from-exception |
| e_ovf | input | 1 | Overflow for the execute-stage instruction |
| m_fault | input | 1 | Data address fault for the memory-stage instruction |
| commit_valid | output | 1 | Memory-stage instruction commits |
| wb_kill | output | 1 | Suppress writeback of the memory-stage instruction |
| kill_fetch | output | 1 | Squash the fetch stage |
| kill_decode | output | 1 | Squash the decode stage |
| kill_execute | output | 1 | Squash the execute stage |
| redirect_valid | output | 1 | Override the next fetch address |
| redirect_pc | output | PC_W | Next fetch address when redirecting |
| cause | output | 4 | Code of the last trap taken |
| epc | output | PC_W | PC of the instruction that trapped |
| kernel_mode | output | 1 | 1 = kernel mode, 0 = user mode |
| irq_enable | output | 1 | Interrupts unmasked |

## Verification
The bench builds the block with a 16-bit PC, a handler address of 0x0800 and no interrupt synchronizer stages. With these values the interrupt request reaches the commit decision in the same cycle, so every cycle's outcome can be predicted exactly. A first sweep sends each of the 16 combinations of the four stage faults through an otherwise empty pipeline, separated by bubbles that carry all four fault flags. This exposes both the stage-priority order and any leak of faults from bubbles. A long pseudo-random phase then mixes bubbles, faults, returns and interrupt requests. Its reference model only sees each instruction's final set of faults, so it reaches back-to-back traps, returns squashed by older traps, and interrupts arriving while masked.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef logic [3:0] cause_t;

   localparam cause_t CAUSE_NONE    = 4'd0;
   localparam cause_t CAUSE_FETCH   = 4'd1;
   localparam cause_t CAUSE_ILLEGAL = 4'd2;
   localparam cause_t CAUSE_OVF     = 4'd3;
   localparam cause_t CAUSE_DADDR   = 4'd4;
   localparam cause_t CAUSE_IRQ     = 4'd8;

   // stages tracked after fetch: decode, execute, memory
   localparam int TRACKED_STAGES = 3;

   typedef struct packed {
      logic   exc;
      cause_t code;
      logic   rfe;
   } exc_tag_t;

   function automatic cause_t stage_cause(input int idx);
      case (idx)
         0:       return CAUSE_ILLEGAL;
         1:       return CAUSE_OVF;
         default: return CAUSE_DADDR;
      endcase
   endfunction

endpackage

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   output logic req_out
);

   if (STAGES < 0) begin : g_bad_stages
      $error("exc_irq_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign req_out = req_in;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= (sh_q << 1) | STAGES'(req_in);
      end
      assign req_out = sh_q[STAGES-1];
   end

endmodule

// File: rtl/exc_stage_slot.sv
module exc_stage_slot
   import exc_pkg::*;
#(
   parameter int     PC_W        = 32,
   parameter cause_t LOCAL_CAUSE = CAUSE_NONE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            in_valid,
   input  logic [PC_W-1:0] in_pc,
   input  exc_tag_t        in_tag,
   input  logic            local_exc,
   input  logic            local_rfe,
   output logic            out_valid,
   output logic [PC_W-1:0] out_pc,
   output exc_tag_t        out_tag
);

   logic            v_q;
   logic [PC_W-1:0] pc_q;
   exc_tag_t        tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         pc_q  <= '0;
         tag_q <= '0;
      end else if (flush) begin
         v_q   <= 1'b0;
         tag_q <= '0;
      end else begin
         v_q   <= in_valid;
         pc_q  <= in_pc;
         tag_q <= in_tag;
      end
   end

   // an older fault keeps its code; this stage's flag only fills an empty tag
   always_comb begin
      out_valid    = v_q;
      out_pc       = pc_q;
      out_tag.exc  = v_q && (tag_q.exc || local_exc);
      out_tag.rfe  = v_q && (tag_q.rfe || local_rfe);
      if (!v_q)
         out_tag.code = CAUSE_NONE;
      else if (tag_q.exc)
         out_tag.code = tag_q.code;
      else if (local_exc)
         out_tag.code = LOCAL_CAUSE;
      else
         out_tag.code = CAUSE_NONE;
   end

   p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);

   p_keep_older_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && in_valid && in_tag.exc) |=> (out_tag.exc && out_tag.code == $past(in_tag.code)));

   p_bubble_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_tag.exc && !out_tag.rfe));

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
   import exc_pkg::*;
#(
   parameter int            PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            m_valid,
   input  logic [PC_W-1:0] m_pc,
   input  exc_tag_t        m_tag,
   input  logic            irq_req,
   output logic            take,
   output logic            rfe_go,
   output logic            commit,
   output logic            redirect_valid,
   output logic [PC_W-1:0] redirect_pc,
   output cause_t          cause_q,
   output logic [PC_W-1:0] epc_q,
   output logic            kernel_q,
   output logic            ie_q
);

   logic   irq_take;
   logic   sync_take;
   cause_t trap_code;

   always_comb begin
      irq_take       = m_valid && ie_q && irq_req;
      sync_take      = m_valid && m_tag.exc;
      take           = irq_take || sync_take;
      trap_code      = irq_take ? CAUSE_IRQ : m_tag.code;
      rfe_go         = m_valid && !take && m_tag.rfe;
      commit         = m_valid && !take;
      redirect_valid = take || rfe_go;
      redirect_pc    = take ? HANDLER_PC : epc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q  <= CAUSE_NONE;
         epc_q    <= '0;
         kernel_q <= 1'b1;
         ie_q     <= 1'b0;
      end else if (take) begin
         cause_q  <= trap_code;
         epc_q    <= m_pc;
         kernel_q <= 1'b1;
         ie_q     <= 1'b0;
      end else if (rfe_go) begin
         kernel_q <= 1'b0;
         ie_q     <= 1'b1;
      end
   end

   p_irq_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && ie_q && irq_req) |=> (cause_q == CAUSE_IRQ));

   p_epc_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (epc_q == $past(m_pc)));

   p_enter_kernel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (kernel_q && !ie_q));

   p_rfe_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rfe_go |=> (!kernel_q && ie_q));

   p_masked_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_q && !m_tag.exc) |-> !take);

   p_bubble_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid |-> (!commit && !redirect_valid));

endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
   import exc_pkg::*;
#(
   parameter int              PC_W        = 32,
   parameter logic [PC_W-1:0] HANDLER_PC  = PC_W'(32'h0000_0100),
   parameter int              SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq,
   input  logic            f_valid,
   input  logic [PC_W-1:0] f_pc,
   input  logic            f_exc,
   input  logic            d_illegal,
   input  logic            d_rfe,
   input  logic            e_ovf,
   input  logic            m_fault,
   output logic            commit_valid,
   output logic            wb_kill,
   output logic            kill_fetch,
   output logic            kill_decode,
   output logic            kill_execute,
   output logic            redirect_valid,
   output logic [PC_W-1:0] redirect_pc,
   output logic [3:0]      cause,
   output logic [PC_W-1:0] epc,
   output logic            kernel_mode,
   output logic            irq_enable
);

   localparam int LAST = TRACKED_STAGES;

   if (PC_W < 8) begin : g_bad_pcw
      $error("exc_commit_ctrl: PC_W must be at least 8");
   end
   if (HANDLER_PC[1:0] != 2'b00) begin : g_bad_handler
      $error("exc_commit_ctrl: HANDLER_PC must be word aligned");
   end

   // index 0 is fetch, 1..LAST are decode, execute, memory
   logic                       st_valid [0:LAST];
   logic [PC_W-1:0]            st_pc    [0:LAST];
   exc_tag_t                   st_tag   [0:LAST];
   logic [TRACKED_STAGES-1:0]  local_exc;
   logic [TRACKED_STAGES-1:0]  local_rfe;

   logic flush;
   logic take;
   logic rfe_go;
   logic irq_req;

   assign local_exc = {m_fault, e_ovf, d_illegal};
   assign local_rfe = {1'b0, 1'b0, d_rfe};

   always_comb begin
      st_valid[0]    = f_valid;
      st_pc[0]       = f_pc;
      st_tag[0].exc  = f_valid && f_exc;
      st_tag[0].code = (f_valid && f_exc) ? CAUSE_FETCH : CAUSE_NONE;
      st_tag[0].rfe  = 1'b0;
   end

   for (genvar g = 0; g < TRACKED_STAGES; g++) begin : g_slot
      exc_stage_slot #(
         .PC_W        (PC_W),
         .LOCAL_CAUSE (stage_cause(g))
      ) i_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (flush),
         .in_valid  (st_valid[g]),
         .in_pc     (st_pc[g]),
         .in_tag    (st_tag[g]),
         .local_exc (local_exc[g]),
         .local_rfe (local_rfe[g]),
         .out_valid (st_valid[g+1]),
         .out_pc    (st_pc[g+1]),
         .out_tag   (st_tag[g+1])
      );
   end

   exc_irq_sync #(
      .STAGES (SYNC_STAGES)
   ) i_irq_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (irq),
      .req_out (irq_req)
   );

   exc_commit_unit #(
      .PC_W       (PC_W),
      .HANDLER_PC (HANDLER_PC)
   ) i_commit (
      .clk            (clk),
      .rst_n          (rst_n),
      .m_valid        (st_valid[LAST]),
      .m_pc           (st_pc[LAST]),
      .m_tag          (st_tag[LAST]),
      .irq_req        (irq_req),
      .take           (take),
      .rfe_go         (rfe_go),
      .commit         (commit_valid),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc),
      .cause_q        (cause),
      .epc_q          (epc),
      .kernel_q       (kernel_mode),
      .ie_q           (irq_enable)
   );

   assign flush        = take || rfe_go;
   assign kill_fetch   = flush;
   assign kill_decode  = flush;
   assign kill_execute = flush;
   assign wb_kill      = take;

   p_trap_kills_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_valid && redirect_pc == HANDLER_PC && !commit_valid) |-> (wb_kill && kill_execute));

   p_no_commit_after_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kill_execute |=> !commit_valid);

   p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_valid && wb_kill));

endmodule

// File: tb/test_exc_commit_ctrl.sv
module test_exc_commit_ctrl;

   localparam int          PC_W    = 16;
   localparam logic [15:0] HANDLER = 16'h0800;
   localparam int          CYCLES  = 3064;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq = 1'b0, f_valid = 1'b0, f_exc = 1'b0;
   logic d_illegal = 1'b0, d_rfe = 1'b0, e_ovf = 1'b0, m_fault = 1'b0;
   logic [15:0] f_pc = '0;
   logic commit_valid, wb_kill, kill_fetch, kill_decode, kill_execute;
   logic redirect_valid, kernel_mode, irq_enable;
   logic [15:0] redirect_pc, epc;
   logic [3:0]  cause;

   always #2.5 clk = ~clk;

   exc_commit_ctrl #(
      .PC_W (PC_W), .HANDLER_PC (HANDLER), .SYNC_STAGES (0)
   ) i_exc_commit_ctrl (
      .clk (clk), .rst_n (rst_n), .irq (irq),
      .f_valid (f_valid), .f_pc (f_pc), .f_exc (f_exc),
      .d_illegal (d_illegal), .d_rfe (d_rfe), .e_ovf (e_ovf), .m_fault (m_fault),
      .commit_valid (commit_valid), .wb_kill (wb_kill),
      .kill_fetch (kill_fetch), .kill_decode (kill_decode), .kill_execute (kill_execute),
      .redirect_valid (redirect_valid), .redirect_pc (redirect_pc),
      .cause (cause), .epc (epc), .kernel_mode (kernel_mode), .irq_enable (irq_enable)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // reference model: slots 1..3 = decode, execute, memory
   // flags bit0 fetch, bit1 decode, bit2 execute, bit3 memory, bit4 return
   bit        mv  [1:3];
   bit [15:0] mpc [1:3];
   bit [4:0]  mfl [1:3];
   bit [3:0]  m_cause;
   bit [15:0] m_epc;
   bit        m_kern, m_ie;

   function automatic bit [3:0] first_code(input bit [3:0] fl);
      if (fl[0]) return 4'd1;
      if (fl[1]) return 4'd2;
      if (fl[2]) return 4'd3;
      return 4'd4;
   endfunction

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      bit        fv;
      bit [15:0] fpc;
      bit [4:0]  ffl;
      bit        iv;
      int        since_flush;
      since_flush = 9;
      for (int s = 1; s <= 3; s++) begin
         mv[s] = 0; mpc[s] = '0; mfl[s] = '0;
      end
      m_cause = 0; m_epc = 0; m_kern = 1; m_ie = 0;

      // R8: reset state
      repeat (3) @(negedge clk);
      #1;
      chk("R8", "kernel_mode", kernel_mode, 1);
      chk("R8", "irq_enable", irq_enable, 0);
      chk("R8", "cause", cause, 0);
      chk("R8", "epc", epc, 0);
      chk("R8", "redirect_valid", redirect_valid, 0);
      chk("R8", "commit_valid", commit_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int c = 0; c < CYCLES; c++) begin
         bit r_take, r_irq, r_sexc, r_rfe, r_commit;
         bit [3:0] r_code;
         bit [31:0] r;
         string ktag;
         @(negedge clk);
         r = $urandom;
         if (c < 64) begin
            // sweep: one instruction per fault combination, then bubbles carrying all flags
            fv  = (c % 4 == 0);
            fpc = 16'(16'h0100 + c * 4);
            ffl = fv ? {1'b0, 4'(c / 4)} : 5'h0F;
            iv  = 1'b0;
         end else begin
            fv  = (r[2:0] != 0);
            fpc = 16'(16'h1000 + c * 4);
            ffl[3:0] = (r[4:3] == 0) ? r[8:5] : 4'h0;
            ffl[4]   = (ffl[3:0] == 0) && (r[11:9] == 0);
            iv  = (r[15:13] == 0);
         end
         f_valid = fv; f_pc = fpc; f_exc = ffl[0];
         d_illegal = mfl[1][1]; d_rfe = mfl[1][4];
         e_ovf = mfl[2][2]; m_fault = mfl[3][3];
         irq = iv;
         #1;
         r_irq    = mv[3] && m_ie && iv;
         r_sexc   = mv[3] && (mfl[3][3:0] != 0);
         r_take   = r_irq || r_sexc;
         r_code   = r_irq ? 4'd8 : first_code(mfl[3][3:0]);
         r_rfe    = mv[3] && !r_take && mfl[3][4];
         r_commit = mv[3] && !r_take;
         ktag     = r_take ? "R4" : (r_rfe ? "R6" : "R1");

         chk(since_flush < 3 ? "R7" : "R9", "commit_valid", commit_valid, r_commit);
         chk(r_take ? "R4" : "R9", "wb_kill", wb_kill, r_take);
         chk(ktag, "kill_fetch", kill_fetch, r_take || r_rfe);
         chk(ktag, "kill_decode", kill_decode, r_take || r_rfe);
         chk(ktag, "kill_execute", kill_execute, r_take || r_rfe);
         chk((iv && !r_irq) ? "R10" : ktag, "redirect_valid", redirect_valid, r_take || r_rfe);
         if (r_take)      chk("R4", "redirect_pc", redirect_pc, HANDLER);
         else if (r_rfe)  chk("R6", "redirect_pc", redirect_pc, m_epc);
         chk(m_cause == 8 ? "R3" : "R2", "cause", cause, m_cause);
         chk("R4", "epc", epc, m_epc);
         chk("R5", "kernel_mode", kernel_mode, m_kern);
         chk("R6", "irq_enable", irq_enable, m_ie);

         // next state
         if (r_take) begin
            m_cause = r_code; m_epc = mpc[3]; m_kern = 1; m_ie = 0;
         end else if (r_rfe) begin
            m_kern = 0; m_ie = 1;
         end
         if (r_take || r_rfe) begin
            for (int s = 1; s <= 3; s++) mv[s] = 0;
            since_flush = 0;
         end else begin
            for (int s = 3; s >= 2; s--) begin
               mv[s] = mv[s-1]; mpc[s] = mpc[s-1]; mfl[s] = mfl[s-1];
            end
            mv[1] = fv; mpc[1] = fpc; mfl[1] = ffl;
            since_flush++;
         end
      end
      finish_run();
   end

endmodule